// File: doc/BRIEF.md
# Per-Module Clock Enable and Reset Controller

This block holds the clock-enable and reset-release bits for a set of on-chip modules and exposes them on a simple register bus. Each control word carries 16 controllable bits. Every write brings a per-bit mask in its upper half, so software can set or clear one module's bit without first reading the word back. The register bits drive the `clk_en` and `mod_rst_n` output vectors directly. Those vectors feed gating cells and reset synchronizers that live outside this block.

Every control word has a mirror monitor word, placed 0x180 bytes higher in the map. The monitor reports the settled state of its control word. It follows the control bits through a configurable pipeline, which models the synchronizer between the control register and the gated domain. Software turns on a clock by setting the mask bit and the value bit together, then polls the monitor until the bit reads 1. It places a module in reset by writing the mask bit with a value of 0, and releases the module by writing the mask bit with a value of 1.

Clock word 0, at byte offset 0, stands for modules that have no gate. Its outputs are always on and it ignores writes. After reset every clock enable is 0, except word 0 and the bits set in a critical-clock parameter. Every module reset line is held asserted.

Top module: `cgr_ctrl`

## Requirements
- R1: After reset, `mod_rst_n` is all zeros and `clk_en` equals the `CRIT_CLK` parameter, with bits 15:0 forced to ones. The control words read back the same values.
- R2: A write to a control word replaces value bit n (for n from 0 to 15) with `wdata[n]` only when `wdata[n+16]` is 1. Every other bit of every output keeps its value.
- R3: Clock words live at byte address 4*i and reset words at 0x080 + 4*j. For both kinds, writing mask 1 with value 1 drives the output bit to 1, and writing mask 1 with value 0 drives it to 0. A `mod_rst_n` bit at 0 holds its module in reset. The output changes in the cycle after the write strobe.
- R4: A read strobe returns the control word's value bits in `bus_rdata[15:0]` and zeros in bits 31:16. The data is valid in the cycle after the strobe.
- R5: The monitor word at control address + 0x180 shows the new control value exactly `MON_LAG` cycles after the control output changes. A read issued k cycles after the write strobe returns the old value for k ≤ `MON_LAG` and the new value for k = `MON_LAG`+1.
- R6: Clock word 0 keeps `clk_en[15:0]` at all ones and ignores writes. Both its control address and its monitor address read 0xFFFF.
- R7: Writes to unmapped addresses change no output. This covers words beyond the configured counts, the gap from 0x100 to 0x17F, misaligned addresses, and monitor addresses. Reads of unmapped addresses return 0.
- R8: `bus_rdata` is 0 in any cycle that does not follow a read strobe.
- R9: A write whose mask half is zero changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: mask in 31:16, value in 15:0 |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| clk_en | output | 16*N_CLK_WORDS | Per-module clock enables |
| mod_rst_n | output | 16*N_RST_WORDS | Per-module reset release (0 = in reset) |

## Verification
The hardest behaviour to observe from the ports is the lag between a control bit and its monitor. The monitor changes a fixed number of cycles after the write, and a read adds one more register stage. The bench therefore issues a write and then back-to-back reads of the monitor on every following cycle. It checks each read against the old or new value by its distance k from the write, so a lag that is off by one cycle in either direction is caught. The bench also checks that no other bit moves during masked sweeps. It does this by keeping its own arithmetic model of every word and comparing the whole output vectors after each write.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned HALF_W    = 16;
    localparam int unsigned IDX_W     = 5;
    localparam logic [11:0] RST_BASE  = 12'h080;
    localparam logic [11:0] BANK_SPAN = 12'h080;
    localparam logic [11:0] MON_OFS   = 12'h180;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_CLK  = 2'd1,
        BK_RST  = 2'd2
    } bank_e;

    typedef struct packed {
        bank_e            bank;
        logic             mon;
        logic [IDX_W-1:0] idx;
    } dec_t;

    // Splits a byte address into bank, monitor flag and word index.
    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t             r;
        logic [ADDR_W-1:0] o;
        r.bank = BK_NONE;
        r.mon  = 1'b0;
        o      = a;
        if (a >= MON_OFS) begin
            r.mon = 1'b1;
            o     = a - MON_OFS;
        end
        if (a[1:0] == 2'b00) begin
            if (o < RST_BASE)
                r.bank = BK_CLK;
            else if (o < RST_BASE + BANK_SPAN)
                r.bank = BK_RST;
        end
        r.idx = o[IDX_W+1:2];
        return r;
    endfunction
endpackage

// File: rtl/cgr_maskbank.sv
module cgr_maskbank import cgr_pkg::*; #(
    parameter int unsigned                 N_WORDS  = 2,
    parameter logic [N_WORDS*HALF_W-1:0]   RST_VAL  = '0,
    parameter bit                          FIXED_W0 = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [N_WORDS*HALF_W-1:0]   val
);
    localparam int unsigned VW = N_WORDS * HALF_W;

    typedef struct packed {
        logic [VW-1:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int w = 0; w < N_WORDS; w++) begin
            if (wr_en && (int'(wr_idx) == w) && !(FIXED_W0 && (w == 0))) begin
                st_d.val[w*HALF_W +: HALF_W] =
                    (st_q.val[w*HALF_W +: HALF_W] & ~wr_data[WORD_W-1:HALF_W]) |
                    (wr_data[HALF_W-1:0] & wr_data[WORD_W-1:HALF_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.val <= RST_VAL;
        else
            st_q <= st_d;
    end

    assign val = st_q.val;
endmodule

// File: rtl/cgr_lagline.sv
module cgr_lagline #(
    parameter int unsigned    W       = 16,
    parameter int unsigned    DEPTH   = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < DEPTH; i++)
            st_d.stg[i] = st_q.stg[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                st_q.stg[i] <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stg[DEPTH-1];
endmodule

// File: rtl/cgr_ctrl.sv
module cgr_ctrl import cgr_pkg::*; #(
    parameter int unsigned                      N_CLK_WORDS = 3,
    parameter int unsigned                      N_RST_WORDS = 2,
    parameter int unsigned                      MON_LAG     = 3,
    parameter logic [N_CLK_WORDS*HALF_W-1:0]    CRIT_CLK    = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_we,
    input  logic [WORD_W-1:0]               bus_wdata,
    input  logic                            bus_re,
    output logic [WORD_W-1:0]               bus_rdata,
    output logic [N_CLK_WORDS*HALF_W-1:0]   clk_en,
    output logic [N_RST_WORDS*HALF_W-1:0]   mod_rst_n
);
    localparam int unsigned CW = N_CLK_WORDS * HALF_W;
    localparam int unsigned RW = N_RST_WORDS * HALF_W;
    localparam logic [CW-1:0] CLK_INIT = CRIT_CLK | CW'({HALF_W{1'b1}});

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    dec_t              dec;
    logic              clk_hit, rst_hit;
    logic              clk_wr, rst_wr;
    logic [HALF_W-1:0] rsel;
    logic [CW-1:0]     clk_q, clk_mon;
    logic [RW-1:0]     rst_q, rst_mon;

    always_comb begin
        dec     = decode(bus_addr);
        clk_hit = (dec.bank == BK_CLK) && (int'(dec.idx) < N_CLK_WORDS);
        rst_hit = (dec.bank == BK_RST) && (int'(dec.idx) < N_RST_WORDS);
        clk_wr  = bus_we && clk_hit && !dec.mon;
        rst_wr  = bus_we && rst_hit && !dec.mon;
    end

    cgr_maskbank #(
        .N_WORDS  (N_CLK_WORDS),
        .RST_VAL  (CLK_INIT),
        .FIXED_W0 (1'b1)
    ) u_clk_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (clk_wr),
        .wr_idx  (dec.idx),
        .wr_data (bus_wdata),
        .val     (clk_q)
    );

    cgr_maskbank #(
        .N_WORDS  (N_RST_WORDS),
        .RST_VAL  ('0),
        .FIXED_W0 (1'b0)
    ) u_rst_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rst_wr),
        .wr_idx  (dec.idx),
        .wr_data (bus_wdata),
        .val     (rst_q)
    );

    for (genvar g = 0; g < N_CLK_WORDS; g++) begin : g_clk_mon
        cgr_lagline #(
            .W       (HALF_W),
            .DEPTH   (MON_LAG),
            .RST_VAL (CLK_INIT[g*HALF_W +: HALF_W])
        ) u_lag (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (clk_q[g*HALF_W +: HALF_W]),
            .dout  (clk_mon[g*HALF_W +: HALF_W])
        );
    end

    for (genvar g = 0; g < N_RST_WORDS; g++) begin : g_rst_mon
        cgr_lagline #(
            .W       (HALF_W),
            .DEPTH   (MON_LAG),
            .RST_VAL ('0)
        ) u_lag (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (rst_q[g*HALF_W +: HALF_W]),
            .dout  (rst_mon[g*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        rsel = '0;
        for (int w = 0; w < N_CLK_WORDS; w++) begin
            if (clk_hit && (int'(dec.idx) == w))
                rsel = dec.mon ? clk_mon[w*HALF_W +: HALF_W] : clk_q[w*HALF_W +: HALF_W];
        end
        for (int w = 0; w < N_RST_WORDS; w++) begin
            if (rst_hit && (int'(dec.idx) == w))
                rsel = dec.mon ? rst_mon[w*HALF_W +: HALF_W] : rst_q[w*HALF_W +: HALF_W];
        end
        st_d       = st_q;
        st_d.rdata = bus_re ? {{(WORD_W-HALF_W){1'b0}}, rsel} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.rdata <= '0;
        else
            st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign clk_en    = clk_q;
    assign mod_rst_n = rst_q;
endmodule

// File: rtl/cgr_ctrl_chk.sv
module cgr_ctrl_chk import cgr_pkg::*; #(
    parameter int unsigned N_CLK_WORDS = 3,
    parameter int unsigned N_RST_WORDS = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_we,
    input logic                            bus_re,
    input logic [WORD_W-1:0]               bus_wdata,
    input logic [WORD_W-1:0]               bus_rdata,
    input logic [N_CLK_WORDS*HALF_W-1:0]   clk_en,
    input logic [N_RST_WORDS*HALF_W-1:0]   mod_rst_n
);
    AST_RESET_HOLDS_MODULES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mod_rst_n == '0)); // R1

    AST_IDLE_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> ($stable(clk_en) && $stable(mod_rst_n))); // R2

    AST_UNMASKED_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we) |-> (((clk_en ^ $past(clk_en)) &
            ~{N_CLK_WORDS{$past(bus_wdata[WORD_W-1:HALF_W])}}) == '0)); // R2

    AST_UNGATED_WORD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en[HALF_W-1:0] == {HALF_W{1'b1}}); // R6

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_re) |-> (bus_rdata == '0)); // R8

    AST_EMPTY_MASK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_wdata[WORD_W-1:HALF_W] == '0)) |=>
            ($stable(clk_en) && $stable(mod_rst_n))); // R9
endmodule

bind cgr_ctrl cgr_ctrl_chk #(
    .N_CLK_WORDS (N_CLK_WORDS),
    .N_RST_WORDS (N_RST_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .clk_en    (clk_en),
    .mod_rst_n (mod_rst_n)
);

// File: tb/cgr_ctrl_bench.sv
`timescale 1ns/1ps
module cgr_ctrl_bench;
    localparam int unsigned NCW = 3;
    localparam int unsigned NRW = 2;
    localparam int unsigned LAG = 3;
    localparam logic [NCW*16-1:0] CRIT = 48'h0000_0004_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       addr = '0;
    logic              we = 1'b0;
    logic [31:0]       wdata = '0;
    logic              re = 1'b0;
    logic [31:0]       rdata;
    logic [NCW*16-1:0] clk_en;
    logic [NRW*16-1:0] mod_rst_n;

    int   n_vec = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    logic [15:0] mclk [NCW];
    logic [15:0] mrst [NRW];

    always #2.5 clk = ~clk;

    cgr_ctrl #(
        .N_CLK_WORDS (NCW),
        .N_RST_WORDS (NRW),
        .MON_LAG     (LAG),
        .CRIT_CLK    (CRIT)
    ) u_cgr_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_re    (re),
        .bus_rdata (rdata),
        .clk_en    (clk_en),
        .mod_rst_n (mod_rst_n)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    function automatic logic [15:0] upd(input logic [15:0] old, input logic [31:0] d);
        return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
    endfunction

    function automatic logic [NCW*16-1:0] clk_vec();
        logic [NCW*16-1:0] v;
        for (int w = 0; w < NCW; w++) v[w*16 +: 16] = mclk[w];
        return v;
    endfunction

    function automatic logic [NRW*16-1:0] rst_vec();
        logic [NRW*16-1:0] v;
        for (int w = 0; w < NRW; w++) v[w*16 +: 16] = mrst[w];
        return v;
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_vec++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] pat;
        logic [NCW*16-1:0] keep_c;
        logic [NRW*16-1:0] keep_r;
        logic [15:0] oldv;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        mclk[0] = 16'hFFFF; mclk[1] = 16'h0004; mclk[2] = 16'h0000;
        for (int w = 0; w < NRW; w++) mrst[w] = 16'h0000;
        chk("R1 clk_en", 64'(clk_en), 64'(clk_vec()));
        chk("R1 mod_rst_n", 64'(mod_rst_n), 64'h0);
        for (int w = 0; w < NCW; w++) begin
            bus_read(12'(4*w), rd);
            chk("R1 clk word read", 64'(rd), 64'({16'h0, mclk[w]}));
        end
        for (int w = 0; w < NRW; w++) begin
            bus_read(12'h080 + 12'(4*w), rd);
            chk("R1 rst word read", 64'(rd), 64'h0);
        end
        // R8 idle after read
        @(negedge clk);
        chk("R8 idle rdata", 64'(rdata), 64'h0);

        // R3 explicit on/off and assert/deassert
        bus_write(12'h008, 32'h0080_0080); mclk[2] = upd(mclk[2], 32'h0080_0080);
        chk("R3 clock on", 64'(clk_en[32+7]), 64'h1);
        bus_write(12'h008, 32'h0080_0000); mclk[2] = upd(mclk[2], 32'h0080_0000);
        chk("R3 clock off", 64'(clk_en[32+7]), 64'h0);
        bus_write(12'h080, 32'h0020_0020); mrst[0] = upd(mrst[0], 32'h0020_0020);
        chk("R3 reset release", 64'(mod_rst_n[5]), 64'h1);
        bus_write(12'h080, 32'h0020_0000); mrst[0] = upd(mrst[0], 32'h0020_0000);
        chk("R3 reset hold", 64'(mod_rst_n[5]), 64'h0);

        // R2 / R3 / R4 masked sweep over all writable words
        pat = 32'h1234_5678;
        for (int r = 0; r < 24; r++) begin
            for (int w = 1; w < NCW; w++) begin
                pat = pat * 32'd1103515245 + 32'd12345;
                bus_write(12'(4*w), pat);
                mclk[w] = upd(mclk[w], pat);
                chk("R2 clk_en after masked write", 64'(clk_en), 64'(clk_vec()));
                bus_read(12'(4*w), rd);
                chk("R4 clk control readback", 64'(rd), 64'({16'h0, mclk[w]}));
            end
            for (int w = 0; w < NRW; w++) begin
                pat = pat * 32'd1103515245 + 32'd12345;
                bus_write(12'h080 + 12'(4*w), pat);
                mrst[w] = upd(mrst[w], pat);
                chk("R3 mod_rst_n after masked write", 64'(mod_rst_n), 64'(rst_vec()));
                bus_read(12'h080 + 12'(4*w), rd);
                chk("R4 rst control readback", 64'(rd), 64'({16'h0, mrst[w]}));
            end
        end

        // R5 monitors settled
        repeat (LAG + 2) @(negedge clk);
        for (int w = 0; w < NCW; w++) begin
            bus_read(12'h180 + 12'(4*w), rd);
            chk("R5 clk monitor settled", 64'(rd), 64'({16'h0, mclk[w]}));
        end
        for (int w = 0; w < NRW; w++) begin
            bus_read(12'h200 + 12'(4*w), rd);
            chk("R5 rst monitor settled", 64'(rd), 64'({16'h0, mrst[w]}));
        end

        // R5 monitor lag, clock word 2
        oldv = mclk[2];
        bus_write(12'h008, {16'hFFFF, ~oldv});
        mclk[2] = ~oldv;
        for (int k = 1; k <= LAG + 2; k++) begin
            bus_read(12'h188, rd);
            chk("R5 clk monitor lag", 64'(rd), 64'({16'h0, (k <= LAG) ? oldv : mclk[2]}));
        end
        // R5 monitor lag, reset word 1
        oldv = mrst[1];
        bus_write(12'h084, {16'hFFFF, ~oldv});
        mrst[1] = ~oldv;
        for (int k = 1; k <= LAG + 2; k++) begin
            bus_read(12'h204, rd);
            chk("R5 rst monitor lag", 64'(rd), 64'({16'h0, (k <= LAG) ? oldv : mrst[1]}));
        end

        // R9 empty mask
        keep_c = clk_en; keep_r = mod_rst_n;
        bus_write(12'h004, 32'h0000_FFFF);
        bus_write(12'h084, 32'h0000_FFFF);
        chk("R9 clk_en unchanged", 64'(clk_en), 64'(keep_c));
        chk("R9 mod_rst_n unchanged", 64'(mod_rst_n), 64'(keep_r));

        // R6 ungated word 0
        bus_write(12'h000, 32'hFFFF_0000);
        chk("R6 word0 enables", 64'(clk_en[15:0]), 64'hFFFF);
        bus_read(12'h000, rd);
        chk("R6 word0 control read", 64'(rd), 64'h0000_FFFF);
        repeat (LAG + 2) @(negedge clk);
        bus_read(12'h180, rd);
        chk("R6 word0 monitor read", 64'(rd), 64'h0000_FFFF);

        // R7 unmapped writes and reads
        keep_c = clk_en; keep_r = mod_rst_n;
        bus_write(12'h100, 32'hFFFF_FFFF);
        bus_write(12'h00C, 32'hFFFF_FFFF);
        bus_write(12'h08C, 32'hFFFF_FFFF);
        bus_write(12'h005, 32'hFFFF_FFFF);
        bus_write(12'h184, 32'hFFFF_FFFF);
        bus_write(12'h204, 32'hFFFF_FFFF);
        bus_write(12'h2A0, 32'hFFFF_FFFF);
        chk("R7 clk_en unchanged", 64'(clk_en), 64'(keep_c));
        chk("R7 mod_rst_n unchanged", 64'(mod_rst_n), 64'(keep_r));
        bus_read(12'h100, rd); chk("R7 read gap", 64'(rd), 64'h0);
        bus_read(12'h00C, rd); chk("R7 read clk beyond count", 64'(rd), 64'h0);
        bus_read(12'h08C, rd); chk("R7 read rst beyond count", 64'(rd), 64'h0);
        bus_read(12'h005, rd); chk("R7 read misaligned", 64'(rd), 64'h0);
        bus_read(12'h2A0, rd); chk("R7 read past monitors", 64'(rd), 64'h0);
        bus_read(12'h18C, rd); chk("R7 read monitor beyond count", 64'(rd), 64'h0);
        @(negedge clk);
        chk("R8 idle rdata end", 64'(rdata), 64'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule